// File: doc/BRIEF.md
# Multi-Mode Timer and Event Counter

This block is a programmable up-counter for small control systems. A 2-bit mode field picks one of three counting sources: prescaled ticks of an internal clock enable (timer), active edges of an external input (event count), or prescaled ticks taken only while the external input sits at a chosen level (pulse-width measurement). When the counter steps past its all-ones value it reloads from a preload register, keeps counting and raises a sticky interrupt request that stays up until it is acknowledged.

Software talks to the block through a small register port with one write and one read select bit. The internal tick source is chosen by one control bit from two clock enables, one standing for the system clock already divided by four and one for a slow on-chip RC clock. A prescaler with up to seven stages divides that source by a power of two. In pulse-width mode the block measures a single pulse and then drops its own run bit, so each measurement must be re-armed by software. The counter width is a parameter, meant for 8-bit and 16-bit instances.

Top module: `tmr_evcnt`

## Requirements
- R1: After reset the control register, the counter and `irq` are all zero.
- R2: Mode 00 is idle: with the run bit set, clock enable pulses and input edges leave the counter unchanged.
- R3: Mode 10 is timer mode: the count advances on prescaled pulses of `sys_ce` when control bit 3 is 0 and of `rc_ce` when it is 1; pulses of the unselected enable are ignored.
- R4: Control bits 2:0 hold k (0 to 7); the counter advances once per 2^k pulses of the selected enable, and the prescaler restarts from zero each time the run bit is set from cleared.
- R5: Mode 01 is event mode: the counter advances once per edge of the synchronised `ev_in`, the rising edge when control bit 4 is 1 and the falling edge when it is 0; clock enables are ignored.
- R6: A step taken while the counter holds all ones loads the preload value instead and sets `irq`.
- R7: `irq` stays set until `irq_ack` is high on a clock edge without a new overflow; an overflow wins over an acknowledge in the same cycle.
- R8: Mode 11 is pulse-width mode: the counter advances on prescaled ticks only while the synchronised `ev_in` equals control bit 4; when that level ends the run bit clears, and later pulses are not counted until software sets the run bit again.
- R9: A preload write while the run bit is 0 also loads the counter; while the run bit is 1 it changes only the preload register.
- R10: Write select 0 addresses the control register (bits 7:6 mode, bit 5 run, bit 4 level/edge, bit 3 clock source, bits 2:0 prescale), write select 1 the preload; read select 0 returns the control register and 1 the counter, one clock after the select is presented.
- R11: With the run bit 0 the counter holds its value in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 preload |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read source: 0 control, 1 counter |
| rd_data | output | DATA_W | Registered read data |
| sys_ce | input | 1 | Enable pulse of the divided system clock |
| rc_ce | input | 1 | Enable pulse of the internal RC clock |
| ev_in | input | 1 | External event or pulse input (asynchronous) |
| irq_ack | input | 1 | Clears the overflow request |
| irq | output | 1 | Overflow interrupt request flag |

## Verification
Timer mode is driven with random preloads, prescale settings and pulse counts on the selected enable mixed with random pulses on the other one, which separates a correct source select and divide ratio from a counter that counts every enable or the wrong power of two. Event mode gets random toggle trains under both edge polarities, telling rising from falling edge counting and showing that clock enables do not leak in. Pulse-width trials raise and drop the input around a burst of ticks and then send a second pulse without re-arming, which distinguishes a one-shot measurement from a free-running gated timer. Directed cases cover preloads near all ones for wrap and flag behaviour, the largest prescale ratio at 127 and 128 pulses, preload writes while running and stopped, and the idle mode.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'b00,
    MODE_EVENT = 2'b01,
    MODE_TIMER = 2'b10,
    MODE_PW    = 2'b11
  } tmr_mode_e;

  typedef struct packed {
    tmr_mode_e  mode;   // [7:6]
    logic       run;    // [5]
    logic       lvl;    // [4] active level / active edge
    logic       src;    // [3] 0: system enable, 1: RC enable
    logic [2:0] psc;    // [2:0] log2 of divide ratio
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);

endpackage

// File: rtl/tmr_insync.sv
module tmr_insync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl  = sh_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int STAGES = 7,
  parameter int SEL_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ce,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [STAGES-1:0] div_q;
  logic [STAGES-1:0] mask;

  // mask covers the low sel bits of the divider
  for (genvar gi = 0; gi < STAGES; gi++) begin : g_mask
    assign mask[gi] = (SEL_W'(gi) < sel);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (ce) begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = ce & (&(div_q | ~mask));

endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         pl_wr,
  input  logic         direct_ld,
  input  logic [W-1:0] pl_data,
  output logic [W-1:0] cnt,
  output logic         wrap
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] preload_q;
  logic [W-1:0] cnt_q;

  assign wrap = step & ~direct_ld & (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      preload_q <= '0;
    end else if (pl_wr) begin
      preload_q <= pl_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (direct_ld) begin
      cnt_q <= pl_data;
    end else if (step) begin
      cnt_q <= (cnt_q == TOP) ? preload_q : cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (step && !direct_ld && cnt_q == TOP) |=> (cnt_q == $past(preload_q))); // R6

endmodule

// File: rtl/tmr_evcnt.sv
module tmr_evcnt
  import tmr_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PSC_STAGES  = 7,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = (CNT_W > 8) ? CNT_W : 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              sys_ce,
  input  logic              rc_ce,
  input  logic              ev_in,
  input  logic              irq_ack,
  output logic              irq
);

  localparam int SEL_W = 3;

  tmr_ctrl_t        ctrl_q;
  logic             ctrl_wr, pl_wr, direct_ld;
  logic             is_tmr, is_evt, is_pw;
  logic             ev_lvl, ev_rise, ev_fall, lvl_ok, evt_hit;
  logic             src_ce, psc_en, psc_tick;
  logic             step, wrap, pw_seen_q, pw_end;
  logic [CNT_W-1:0] cnt;
  logic             irq_q;
  logic [DATA_W-1:0] rd_q;

  assign ctrl_wr   = wr_en & ~wr_sel;
  assign pl_wr     = wr_en & wr_sel;
  assign direct_ld = pl_wr & ~ctrl_q.run;

  assign is_tmr = (ctrl_q.mode == MODE_TIMER);
  assign is_evt = (ctrl_q.mode == MODE_EVENT);
  assign is_pw  = (ctrl_q.mode == MODE_PW);

  tmr_insync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (ev_in),
    .lvl (ev_lvl),
    .rise(ev_rise),
    .fall(ev_fall)
  );

  assign lvl_ok  = (ev_lvl == ctrl_q.lvl);
  assign evt_hit = ctrl_q.lvl ? ev_rise : ev_fall;
  assign src_ce  = ctrl_q.src ? rc_ce : sys_ce;
  assign psc_en  = ctrl_q.run & src_ce & (is_tmr | (is_pw & lvl_ok));

  tmr_prescale #(.STAGES(PSC_STAGES), .SEL_W(SEL_W)) u_psc (
    .clk (clk),
    .rst (rst),
    .clr (~ctrl_q.run),
    .ce  (psc_en),
    .sel (ctrl_q.psc),
    .tick(psc_tick)
  );

  assign step = ctrl_q.run & (((is_tmr | is_pw) & psc_tick) | (is_evt & evt_hit));

  tmr_core #(.W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .pl_wr    (pl_wr),
    .direct_ld(direct_ld),
    .pl_data  (wr_data[CNT_W-1:0]),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  // one-shot pulse tracking: seen the active level since arming
  always_ff @(posedge clk) begin
    if (rst || !ctrl_q.run || ctrl_wr) begin
      pw_seen_q <= 1'b0;
    end else if (is_pw && lvl_ok) begin
      pw_seen_q <= 1'b1;
    end
  end

  assign pw_end = ctrl_q.run & is_pw & pw_seen_q & ~lvl_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
    end else if (pw_end) begin
      ctrl_q.run <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
    end else if (wrap) begin
      irq_q <= 1'b1;
    end else if (irq_ack) begin
      irq_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_sel ? DATA_W'(cnt) : DATA_W'(ctrl_q);
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.mode == MODE_IDLE && !wr_en) |=> $stable(cnt)); // R2

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q.run && !wr_en) |=> $stable(cnt)); // R11

  AST_SRC_GATED: assert property (@(posedge clk) disable iff (rst)
    (is_tmr && !src_ce && !wr_en) |=> $stable(cnt)); // R3

  AST_EVT_COUNT: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && is_evt && evt_hit && !wr_en && cnt != {CNT_W{1'b1}})
      |=> (cnt == $past(cnt) + 1'b1)); // R5

  AST_RUN_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && !wr_en) |=> (ctrl_q.run || $past(ctrl_q.mode) == MODE_PW)); // R8

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq); // R7

endmodule

// File: tb/tmr_evcnt_test.sv
module tmr_evcnt_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       sys_ce = 1'b0, rc_ce = 1'b0, ev_in = 1'b0, irq_ack = 1'b0;
  logic       irq;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  tmr_evcnt uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sys_ce(sys_ce), .rc_ce(rc_ce),
    .ev_in(ev_in), .irq_ack(irq_ack), .irq(irq)
  );

  function automatic logic [7:0] mk(logic [1:0] m, logic r, logic l, logic s, logic [2:0] k);
    return {m, r, l, s, k};
  endfunction

  // {overflow, value} after n steps from s with reload pl
  function automatic logic [8:0] adv(logic [7:0] s, logic [7:0] pl, int n);
    logic [7:0] v = s;
    logic       o = 1'b0;
    for (int i = 0; i < n; i++) begin
      if (v == 8'hFF) begin v = pl; o = 1'b1; end
      else v = v + 8'd1;
    end
    return {o, v};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [7:0] v);
    rd_sel = sel;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse(logic which);
    if (which) rc_ce = 1'b1; else sys_ce = 1'b1;
    @(negedge clk);
    rc_ce = 1'b0; sys_ce = 1'b0;
    @(negedge clk);
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v, pl, exp_c;
    logic [8:0] r;
    void'($urandom(32'd1234));
    cyc(3);
    rst = 1'b0;
    cyc(1);

    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(1'b0, v); chk("R1 ctrl", v, 8'h00);
    rd(1'b1, v); chk("R1 cnt", v, 8'h00);

    // R10 control readback
    wr(1'b0, mk(2'b01, 1'b0, 1'b1, 1'b1, 3'd5));
    rd(1'b0, v); chk("R10 ctrl readback", v, 8'h5D);

    // R3 R4 R6 random timer trials
    for (int t = 0; t < 14; t++) begin
      logic s; logic [2:0] k; int n;
      k = 3'($urandom % 4); s = 1'($urandom % 2); n = $urandom % 24;
      pl = (t % 2 == 1) ? (8'hF0 | 8'($urandom % 16)) : 8'($urandom);
      wr(1'b0, mk(2'b10, 1'b0, 1'b0, s, k));
      ack();
      wr(1'b1, pl);
      wr(1'b0, mk(2'b10, 1'b1, 1'b0, s, k));
      for (int i = 0; i < n; i++) begin
        pulse(s);
        if ($urandom % 2 == 1) pulse(~s);
      end
      wr(1'b0, mk(2'b10, 1'b0, 1'b0, s, k));
      r = adv(pl, pl, n >> k);
      rd(1'b1, v); chk("R3 R4 timer count", v, r[7:0]);
      chk("R6 timer overflow flag", {7'd0, irq}, {7'd0, r[8]});
    end

    // R4 largest ratio
    wr(1'b1, 8'h20);
    ack();
    wr(1'b0, mk(2'b10, 1'b1, 1'b0, 1'b0, 3'd7));
    for (int i = 0; i < 127; i++) pulse(1'b0);
    rd(1'b1, v); chk("R4 ratio 128 before", v, 8'h20);
    pulse(1'b0);
    rd(1'b1, v); chk("R4 ratio 128 after", v, 8'h21);

    // R9 preload write while running does not touch the counter
    wr(1'b1, 8'h33);
    rd(1'b1, v); chk("R9 running preload", v, 8'h21);
    wr(1'b0, mk(2'b10, 1'b0, 1'b0, 1'b0, 3'd0));
    // R11 stopped counter holds
    pulse(1'b0); pulse(1'b1);
    rd(1'b1, v); chk("R11 stopped hold", v, 8'h21);
    wr(1'b1, 8'h44);
    rd(1'b1, v); chk("R9 stopped preload", v, 8'h44);

    // R6 R7 directed wrap and sticky flag
    wr(1'b1, 8'hFF);
    ack();
    wr(1'b0, mk(2'b10, 1'b1, 1'b0, 1'b0, 3'd0));
    pulse(1'b0);
    wr(1'b0, mk(2'b10, 1'b0, 1'b0, 1'b0, 3'd0));
    rd(1'b1, v); chk("R6 reload value", v, 8'hFF);
    cyc(4);
    chk("R7 flag held", {7'd0, irq}, 8'h01);
    ack();
    chk("R7 flag cleared", {7'd0, irq}, 8'h00);

    // R2 idle mode
    wr(1'b1, 8'h10);
    wr(1'b0, mk(2'b00, 1'b1, 1'b1, 1'b0, 3'd0));
    for (int i = 0; i < 4; i++) begin
      pulse(1'b0); pulse(1'b1);
      ev_in = ~ev_in; cyc(4);
    end
    rd(1'b1, v); chk("R2 idle hold", v, 8'h10);

    // R5 random event trials
    for (int t = 0; t < 10; t++) begin
      logic l; int n, hits;
      l = 1'($urandom % 2); n = $urandom % 14; hits = 0;
      pl = (t % 3 == 0) ? 8'hFC : 8'($urandom);
      wr(1'b0, mk(2'b01, 1'b0, l, 1'b0, 3'd0));
      ev_in = ~l; cyc(4);
      ack();
      wr(1'b1, pl);
      wr(1'b0, mk(2'b01, 1'b1, l, 1'b0, 3'd0));
      for (int i = 0; i < n; i++) begin
        ev_in = ~ev_in;
        if (ev_in == l) hits++;
        pulse(1'b0); pulse(1'b1);
      end
      cyc(5);
      wr(1'b0, mk(2'b01, 1'b0, l, 1'b0, 3'd0));
      r = adv(pl, pl, hits);
      rd(1'b1, v); chk("R5 event count", v, r[7:0]);
      chk("R6 event overflow flag", {7'd0, irq}, {7'd0, r[8]});
    end

    // R8 random pulse-width trials
    for (int t = 0; t < 6; t++) begin
      logic l, s; logic [2:0] k; int n;
      l = 1'($urandom % 2); s = 1'($urandom % 2);
      k = 3'($urandom % 3); n = 1 + $urandom % 20;
      pl = 8'($urandom % 128);
      wr(1'b0, mk(2'b11, 1'b0, l, s, k));
      ev_in = ~l; cyc(4);
      wr(1'b1, pl);
      wr(1'b0, mk(2'b11, 1'b1, l, s, k));
      pulse(s); pulse(s);           // before the pulse: not counted
      ev_in = l; cyc(3);
      for (int i = 0; i < n; i++) begin
        pulse(s);
        if ($urandom % 2 == 1) pulse(~s);
      end
      ev_in = ~l; cyc(5);
      exp_c = pl + 8'(n >> k);
      rd(1'b1, v); chk("R8 pulse width", v, exp_c);
      rd(1'b0, v); chk("R8 run cleared", v, mk(2'b11, 1'b0, l, s, k));
      ev_in = l; cyc(3);
      for (int i = 0; i < 8; i++) pulse(s);
      ev_in = ~l; cyc(5);
      rd(1'b1, v); chk("R8 second pulse ignored", v, exp_c);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule